// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block walks a single-data-rate SDRAM array through its power-up ritual by steering the 3-bit command-mode field of a memory controller. The sequence starts on a one-cycle start pulse. It issues no-operation, then precharge-all, then a series of CBR auto-refresh cycles, then a mode-register load, and finally switches the controller to normal operation. Each step sets the mode code and then makes two dummy accesses on consecutive cycles. The first goes to the array base plus a step offset. The second goes to the base of the next row plus the same offset. These accesses are what actually deliver the command to the devices.

Waits between steps are measured in microseconds. They are counted from an external clock-enable tick, with a parameter giving the number of ticks per microsecond. When the normal step is entered, the block also raises a refresh-interval field and an init-complete bit for the controller. A done flag reports that the whole ritual is over. The DRAM data path, bank timing and module sizing live elsewhere.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: After reset, `mode_code` is 0, `acc_strobe` is 0, `rfsh_mode` is 0, `init_cmplt` is 0 and `done` is 0.
- R2: Mode codes follow the order no-op (1), precharge-all (2), CBR refresh (6), mode-register load (3), normal (7). `mode_code` takes each new value in the cycle of that step's first dummy access.
- R3: Every step drives `acc_strobe` for two consecutive cycles. The first access goes to address 0 plus the step offset, and the second to `row_base` plus the step offset. The offset is 0x1D0 for the mode-register load and 0 for every other step.
- R4: The wait after a step's last access lasts a set number of microseconds: no-op 200, precharge-all 1, each refresh iteration 1, mode-register load 2, normal 1. One microsecond is CYC_PER_US `us_tick` pulses, and only pulses seen in non-access cycles count.
- R5: The CBR step issues its command pair. It then issues 8 refresh iterations, each an access pair followed by a 1 us wait. The first iteration follows the command pair with no wait.
- R6: `rfsh_mode` is 1 and `init_cmplt` is 1 from the cycle normal mode is entered. Both are 0 in every other mode.
- R7: `done` rises in the cycle after the last counted tick of the normal step's wait. It then stays 1, with `mode_code` held at 7, until the next start.
- R8: A start pulse that arrives while the sequence is running has no effect on the codes, accesses or waits.
- R9: A start after `done` restarts the sequence from no-op. It clears `done`, `rfsh_mode` and `init_cmplt` in the cycle of the first access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to run the sequence |
| us_tick | input | 1 | Clock-enable tick; CYC_PER_US of them form one microsecond |
| row_base | input | AW | Base address of the next row |
| mode_code | output | 3 | Command-mode code for the controller |
| acc_strobe | output | 1 | Dummy access request, one per cycle |
| acc_addr | output | AW | Address of the dummy access |
| rfsh_mode | output | RF_W | Refresh-interval field (1 in normal mode) |
| init_cmplt | output | 1 | Init-complete bit for the controller |
| done | output | 1 | Sequence finished |

## Verification
Two things can land in the same cycle: a dummy access and a `us_tick` pulse. The wait counter must not take a tick while an access is being made. One run holds `us_tick` high on every cycle, so each access cycle carries a tick. The scoreboard counts ticks only in cycles without an access and compares that count with the wait the requirements give for the step. A second collision is a start pulse during the 200 us no-op wait. The scoreboard then sees no extra accesses, and the expected order is unchanged.

// File: rtl/sdram_pwrup_pkg.sv
`timescale 1ns/1ps
package sdram_pwrup_pkg;

   typedef enum logic [2:0] {
      MC_IDLE   = 3'd0,
      MC_NOP    = 3'd1,
      MC_PRECHG = 3'd2,
      MC_MRS    = 3'd3,
      MC_CBR    = 3'd6,
      MC_NORMAL = 3'd7
   } mode_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ACC0,
      ST_ACC1,
      ST_WAIT
   } seq_state_e;

   function automatic mode_e succ_mode(mode_e m);
      case (m)
         MC_NOP:    return MC_PRECHG;
         MC_PRECHG: return MC_CBR;
         MC_CBR:    return MC_MRS;
         MC_MRS:    return MC_NORMAL;
         default:   return MC_NOP;
      endcase
   endfunction

   function automatic logic legal_step(mode_e from_m, mode_e to_m);
      return (to_m == MC_NOP) || (to_m == succ_mode(from_m));
   endfunction

endpackage

// File: rtl/sdram_us_timer.sv
`timescale 1ns/1ps
module sdram_us_timer #(
   parameter int CYC_PER_US = 133,
   parameter int US_W       = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [US_W-1:0] load_us,
   input  logic            tick,
   output logic            expire
);

   logic            active_q;
   logic [US_W-1:0] us_q;
   logic            us_pulse;

   generate
      if (CYC_PER_US == 1) begin : g_direct
         assign us_pulse = tick;
      end else begin : g_prescale
         localparam int PW = $clog2(CYC_PER_US);
         localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 pre_q <= '0;
            else if (load)              pre_q <= '0;
            else if (active_q && tick)  pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
         end
         assign us_pulse = tick && (pre_q == PRE_LAST);
      end
   endgenerate

   assign expire = active_q && us_pulse && (us_q == US_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         us_q     <= '0;
      end else if (load) begin
         active_q <= 1'b1;
         us_q     <= load_us;
      end else if (active_q && us_pulse) begin
         us_q <= us_q - 1'b1;
         if (us_q == US_W'(1)) active_q <= 1'b0;
      end
   end

   assert_count_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (us_q != '0));
   assert_load_when_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !active_q);
   assert_expire_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !active_q);

endmodule

// File: rtl/sdram_acc_gen.sv
`timescale 1ns/1ps
module sdram_acc_gen
   import sdram_pwrup_pkg::*;
#(
   parameter int AW         = 32,
   parameter int MRS_OFFSET = 'h1D0
) (
   input  logic [2:0]    mode,
   input  logic          phase,
   input  logic [AW-1:0] row_base,
   output logic [AW-1:0] addr
);

   logic [AW-1:0] base_sel;
   logic [AW-1:0] ofs_sel;

   always_comb begin
      base_sel = phase ? row_base : '0;
      ofs_sel  = (mode == 3'(MC_MRS)) ? AW'(MRS_OFFSET) : '0;
      addr     = base_sel + ofs_sel;
   end

endmodule

// File: rtl/sdram_seq_fsm.sv
`timescale 1ns/1ps
module sdram_seq_fsm
   import sdram_pwrup_pkg::*;
#(
   parameter int REF_LOOPS = 8,
   parameter int NOP_US    = 200,
   parameter int PRE_US    = 1,
   parameter int REF_US    = 1,
   parameter int MRS_US    = 2,
   parameter int NRM_US    = 1,
   parameter int US_W      = 8,
   parameter int RF_W      = 3,
   parameter int REF_CODE  = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            expire,
   output logic            load,
   output logic [US_W-1:0] load_us,
   output logic [2:0]      mode,
   output logic            acc_strobe,
   output logic            acc_phase,
   output logic [RF_W-1:0] rfsh,
   output logic            ic,
   output logic            done
);

   localparam int IT_W = $clog2(REF_LOOPS + 1);
   localparam logic [IT_W-1:0] IT_LAST = IT_W'(REF_LOOPS);

   seq_state_e      state_q;
   mode_e           mode_q;
   logic [IT_W-1:0] iter_q;
   logic            done_q;
   logic            ic_q;
   logic [RF_W-1:0] rfsh_q;
   logic            cbr_cmd_pair;

   assign cbr_cmd_pair = (mode_q == MC_CBR) && (iter_q == '0);
   assign load         = (state_q == ST_ACC1) && !cbr_cmd_pair;
   assign acc_strobe   = (state_q == ST_ACC0) || (state_q == ST_ACC1);
   assign acc_phase    = (state_q == ST_ACC1);
   assign mode         = mode_q;
   assign rfsh         = rfsh_q;
   assign ic           = ic_q;
   assign done         = done_q;

   always_comb begin
      case (mode_q)
         MC_NOP:    load_us = US_W'(NOP_US);
         MC_PRECHG: load_us = US_W'(PRE_US);
         MC_CBR:    load_us = US_W'(REF_US);
         MC_MRS:    load_us = US_W'(MRS_US);
         default:   load_us = US_W'(NRM_US);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= MC_IDLE;
         iter_q  <= '0;
         done_q  <= 1'b0;
         ic_q    <= 1'b0;
         rfsh_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_ACC0;
                  mode_q  <= MC_NOP;
                  iter_q  <= '0;
                  done_q  <= 1'b0;
                  ic_q    <= 1'b0;
                  rfsh_q  <= '0;
               end
            end
            ST_ACC0: state_q <= ST_ACC1;
            ST_ACC1: begin
               if (cbr_cmd_pair) begin
                  iter_q  <= iter_q + 1'b1;
                  state_q <= ST_ACC0;
               end else begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (expire) begin
                  if ((mode_q == MC_CBR) && (iter_q < IT_LAST)) begin
                     iter_q  <= iter_q + 1'b1;
                     state_q <= ST_ACC0;
                  end else if (mode_q == MC_NORMAL) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     mode_q  <= succ_mode(mode_q);
                     state_q <= ST_ACC0;
                     iter_q  <= '0;
                     if (succ_mode(mode_q) == MC_NORMAL) begin
                        rfsh_q <= RF_W'(REF_CODE);
                        ic_q   <= 1'b1;
                     end
                  end
               end
            end
         endcase
      end
   end

   assert_mode_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_q) |-> legal_step($past(mode_q), mode_q));
   assert_pair_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_strobe && !acc_phase) |=> (acc_strobe && acc_phase));
   assert_iter_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      iter_q <= IT_LAST);
   assert_iter_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MC_CBR) |-> (iter_q == '0));
   assert_normal_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ic_q |-> ((mode_q == MC_NORMAL) && (rfsh_q == RF_W'(REF_CODE))));
   assert_flags_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MC_NORMAL) |-> (!ic_q && (rfsh_q == '0)));
   assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!acc_strobe && (mode_q == MC_NORMAL)));
   assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && acc_strobe && !acc_phase) |=> (acc_strobe && acc_phase && $stable(mode_q)));

endmodule

// File: rtl/sdram_pwrup_seq.sv
`timescale 1ns/1ps
module sdram_pwrup_seq #(
   parameter int AW          = 32,
   parameter int CYC_PER_US  = 133,
   parameter int REF_LOOPS   = 8,
   parameter int NOP_WAIT_US = 200,
   parameter int PRE_WAIT_US = 1,
   parameter int REF_WAIT_US = 1,
   parameter int MRS_WAIT_US = 2,
   parameter int NRM_WAIT_US = 1,
   parameter int MRS_OFFSET  = 'h1D0,
   parameter int RF_W        = 3,
   parameter int REF_CODE    = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            us_tick,
   input  logic [AW-1:0]   row_base,
   output logic [2:0]      mode_code,
   output logic            acc_strobe,
   output logic [AW-1:0]   acc_addr,
   output logic [RF_W-1:0] rfsh_mode,
   output logic            init_cmplt,
   output logic            done
);

   localparam int MAX_A  = (NOP_WAIT_US > PRE_WAIT_US) ? NOP_WAIT_US : PRE_WAIT_US;
   localparam int MAX_B  = (REF_WAIT_US > MRS_WAIT_US) ? REF_WAIT_US : MRS_WAIT_US;
   localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_US = (MAX_AB > NRM_WAIT_US) ? MAX_AB : NRM_WAIT_US;
   localparam int US_W   = $clog2(MAX_US + 1);

   generate
      if (CYC_PER_US < 1) begin : g_chk_cyc
         $error("CYC_PER_US must be at least 1");
      end
      if (REF_LOOPS < 1) begin : g_chk_loops
         $error("REF_LOOPS must be at least 1");
      end
      if (NOP_WAIT_US < 1 || PRE_WAIT_US < 1 || REF_WAIT_US < 1 ||
          MRS_WAIT_US < 1 || NRM_WAIT_US < 1) begin : g_chk_wait
         $error("every wait must be at least 1 us");
      end
      if (AW < 12 || MRS_OFFSET >= (1 << 12) || MRS_OFFSET < 0) begin : g_chk_aw
         $error("address must hold the mode-load offset");
      end
      if (REF_CODE < 1 || REF_CODE >= (1 << RF_W)) begin : g_chk_ref
         $error("REF_CODE must be nonzero and fit RF_W");
      end
   endgenerate

   logic            load;
   logic [US_W-1:0] load_us;
   logic            expire;
   logic            acc_phase;

   sdram_seq_fsm #(
      .REF_LOOPS (REF_LOOPS),
      .NOP_US    (NOP_WAIT_US),
      .PRE_US    (PRE_WAIT_US),
      .REF_US    (REF_WAIT_US),
      .MRS_US    (MRS_WAIT_US),
      .NRM_US    (NRM_WAIT_US),
      .US_W      (US_W),
      .RF_W      (RF_W),
      .REF_CODE  (REF_CODE)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .expire     (expire),
      .load       (load),
      .load_us    (load_us),
      .mode       (mode_code),
      .acc_strobe (acc_strobe),
      .acc_phase  (acc_phase),
      .rfsh       (rfsh_mode),
      .ic         (init_cmplt),
      .done       (done)
   );

   sdram_us_timer #(
      .CYC_PER_US (CYC_PER_US),
      .US_W       (US_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .load_us (load_us),
      .tick    (us_tick),
      .expire  (expire)
   );

   sdram_acc_gen #(
      .AW         (AW),
      .MRS_OFFSET (MRS_OFFSET)
   ) u_acc (
      .mode     (mode_code),
      .phase    (acc_phase),
      .row_base (row_base),
      .addr     (acc_addr)
   );

   assert_strobe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd0) |-> (!acc_strobe && !done));

endmodule

// File: tb/sdram_pwrup_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_pwrup_seq_tb_top;

   localparam int AW  = 32;
   localparam int CPU = 3;

   typedef struct {
      logic [2:0]  mode;
      logic [31:0] addr;
      int          gap;
      logic [2:0]  rf;
      logic        ic;
      logic        fin;
      string       req;
   } item_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic            us_tick = 1'b0;
   logic [AW-1:0]   row_base = '0;
   logic [2:0]      mode_code;
   logic            acc_strobe;
   logic [AW-1:0]   acc_addr;
   logic [2:0]      rfsh_mode;
   logic            init_cmplt;
   logic            done;

   int    n_vec = 0;
   int    n_bad = 0;
   int    gap = 0;
   bit    running = 1'b0;
   int    tick_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   item_t q[$];

   always #10 clk = ~clk;

   sdram_pwrup_seq #(.AW(AW), .CYC_PER_US(CPU)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick),
      .row_base(row_base), .mode_code(mode_code), .acc_strobe(acc_strobe),
      .acc_addr(acc_addr), .rfsh_mode(rfsh_mode), .init_cmplt(init_cmplt),
      .done(done));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push_item(input logic [2:0] m, input logic [31:0] a, input int g,
                            input logic [2:0] rf, input logic icb, input logic fin,
                            input string req);
      item_t it;
      it.mode = m; it.addr = a; it.gap = g; it.rf = rf; it.ic = icb;
      it.fin = fin; it.req = req;
      q.push_back(it);
   endtask

   task automatic push_pair(input logic [2:0] m, input logic [31:0] ofs, input int g,
                            input logic [31:0] row, input string req);
      logic [2:0] rf = (m == 3'd7) ? 3'd1 : 3'd0;
      logic       icb = (m == 3'd7);
      push_item(m, ofs, g, rf, icb, 1'b0, req);
      push_item(m, row + ofs, 0, rf, icb, 1'b0, req);
   endtask

   // Expected sequence built from the requirements
   task automatic build_expect(input logic [31:0] row);
      push_pair(3'd1, 32'h0, 0, row, "R2 R3 R9");
      push_pair(3'd2, 32'h0, 200 * CPU, row, "R2 R4");
      push_pair(3'd6, 32'h0, 1 * CPU, row, "R2 R4");
      for (int k = 1; k <= 8; k++)
         push_pair(3'd6, 32'h0, (k == 1) ? 0 : CPU, row, "R5");
      push_pair(3'd3, 32'h1D0, 1 * CPU, row, "R2 R3 R5");
      push_pair(3'd7, 32'h0, 2 * CPU, row, "R4 R6");
      push_item(3'd7, 32'h0, 1 * CPU, 3'd1, 1'b1, 1'b1, "R7");
   endtask

   task automatic pulse_start(input bit set_run);
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      if (set_run) begin gap = 0; running = 1'b1; end
   endtask

   // Tick driver
   initial begin
      forever begin
         @(posedge clk); #1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (tick_mode)
            0:       us_tick = ~us_tick;
            1:       us_tick = lfsr[0];
            default: us_tick = 1'b1;
         endcase
      end
   end

   // Monitor / scoreboard
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         if (!rst_n) continue;
         if (acc_strobe) begin
            if (q.size() == 0 || q[0].fin) begin
               chk(1'b0, "R8", "unexpected access addr", acc_addr, 0);
            end else begin
               it = q.pop_front();
               chk(mode_code == it.mode, it.req, "mode", mode_code, it.mode);
               chk(acc_addr == it.addr, it.req, "addr", acc_addr, it.addr);
               chk(gap == it.gap, it.req, "wait ticks", gap, it.gap);
               chk(rfsh_mode == it.rf && init_cmplt == it.ic, it.req, "rfsh/ic",
                   {rfsh_mode, init_cmplt}, {it.rf, it.ic});
               chk(!done, it.req, "done during run", done, 0);
            end
            gap = 0;
         end else if (running) begin
            if (done) begin
               if (q.size() == 0 || !q[0].fin) begin
                  chk(1'b0, "R7", "early done, items left", q.size(), 1);
               end else begin
                  it = q.pop_front();
                  chk(gap == it.gap, "R7", "final wait ticks", gap, it.gap);
                  chk(mode_code == 3'd7 && rfsh_mode == 3'd1 && init_cmplt,
                      "R6 R7", "final state", {mode_code, rfsh_mode, init_cmplt},
                      {3'd7, 3'd1, 1'b1});
               end
               running = 1'b0;
            end else if (us_tick) begin
               gap++;
            end
         end
      end
   end

   task automatic run_seq(input logic [31:0] row, input int tmode, input bit poke);
      tick_mode = tmode;
      row_base  = row;
      build_expect(row);
      pulse_start(1'b1);
      if (poke) begin
         repeat (40) @(posedge clk);
         pulse_start(1'b0);
         @(negedge clk);
         chk(mode_code == 3'd1, "R8", "mode after busy start", mode_code, 1);
      end
      while (running) @(negedge clk);
      chk(q.size() == 0, "R2", "items left", q.size(), 0);
   endtask

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(mode_code == 3'd0, "R1", "reset mode", mode_code, 0);
      chk(!acc_strobe && !done, "R1", "reset strobe/done", {acc_strobe, done}, 0);
      chk(rfsh_mode == 3'd0 && !init_cmplt, "R1", "reset rfsh/ic",
          {rfsh_mode, init_cmplt}, 0);

      run_seq(32'h0400_0000, 0, 1'b1);
      repeat (5) @(negedge clk);
      chk(done && mode_code == 3'd7 && !acc_strobe, "R7", "done held",
          {done, mode_code, acc_strobe}, {1'b1, 3'd7, 1'b0});

      run_seq(32'h0000_1000, 1, 1'b0);
      run_seq(32'hFFFF_F000, 2, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule